// File: doc/BRIEF.md
# Keyboard Controller Host Command Engine

This block is the host-side register engine of a PC-style keyboard controller. The host reaches it through a byte-wide port that has two addresses. Address 0 is the data port. Address 1 is the command/status port. A command byte written to address 1 may act at once: it can update the mode byte, drive the A20 gate, request a system reset, or queue a reply byte. It may instead latch itself as a pending command. In that case the next byte written to the data port is steered by the latched code. The byte can go to the mode register, to the output port, back to the host as a reply tagged for the keyboard or for the auxiliary device, or out to the auxiliary device. When nothing is latched, data bytes go to the keyboard transmit path.

Every result is a registered output. Replies and transmit bytes are single-cycle strobes with a data byte. System reset, interrupt re-evaluation and unknown-command error are single-cycle pulses. The A20 level and the scan-code translation enable are held levels. Serial line protocols, device FIFOs and interrupt arbitration are handled by neighbouring blocks.

Top module: `kbc_host_engine`

## Requirements
- R1: After synchronous reset the mode byte is 0x03, the status byte is 0x18, the output port is 0xCF, A20 is high, translation is off, and every strobe is low.
- R2: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 produce no strobe and change no register. They only latch the code that routes the next data-port write. The latch clears after that write, whatever its code.
- R3: A data-port write with no latched command is sent on the keyboard transmit strobe with the same byte.
- R4: The following commands each produce a reply strobe with the auxiliary tag at 0: 0x20 returns the mode byte, 0xAA returns 0x55 and sets status bit 2, 0xA9 and 0xAB return 0x00, 0xC0 returns 0x80, and 0xD0 returns the current output port.
- R5: 0xA7 sets mode bit 5 and 0xA8 clears it. 0xAD sets mode bit 4 and 0xAE clears it. Each of 0xAD and 0xAE also pulses the interrupt re-evaluation output.
- R6: 0xDF sets output-port bit 1 and raises A20. 0xDD clears bit 1 and lowers A20.
- R7: A command whose upper four bits are all ones is folded. With bit 0 clear it pulses system reset for one cycle. With bit 0 set it does nothing.
- R8: A data write after 0xD1 stores the byte in the output port and sets A20 from bit 1. It pulses system reset when bit 0 is zero.
- R9: A data write after 0x60 stores the mode byte, sets translation enable from bit 6, and pulses interrupt re-evaluation.
- R10: Status bit 3 becomes 1 after any command-port write and 0 after any data-port write.
- R11: An unrecognised command pulses the error output for one cycle and leaves the mode, the output port, A20 and the latch unchanged.
- R12: A data write after 0xD2 is replied with the auxiliary tag at 0. After 0xD3 it is replied with the tag at 1. After 0xD4 it is sent on the auxiliary transmit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_addr | input | 1 | 0 = data port, 1 = command port |
| host_wdata | input | 8 | Written byte |
| status_o | output | 8 | Status byte |
| mode_o | output | 8 | Mode byte |
| outport_o | output | 8 | Output port byte |
| a20_o | output | 1 | A20 gate level |
| xlat_en_o | output | 1 | Scan-code translation enable |
| sys_reset_o | output | 1 | One-cycle system reset request |
| irq_eval_o | output | 1 | One-cycle interrupt re-evaluation pulse |
| cmd_err_o | output | 1 | One-cycle unknown-command pulse |
| rsp_valid_o | output | 1 | Reply byte strobe |
| rsp_aux_o | output | 1 | Reply tag: 1 = auxiliary, 0 = keyboard |
| rsp_data_o | output | 8 | Reply byte |
| kbd_tx_valid_o | output | 1 | Keyboard transmit strobe |
| kbd_tx_data_o | output | 8 | Keyboard transmit byte |
| aux_tx_valid_o | output | 1 | Auxiliary transmit strobe |
| aux_tx_data_o | output | 8 | Auxiliary transmit byte |

## Verification
A write strobe sampled at one rising edge shows all of its effects after that same edge. These effects are register updates, levels and one-cycle strobes, and each one is due exactly one cycle after the stimulus. The bench drives each access on a falling edge. It compares every output against its model at the next falling edge, which lies after the single capturing edge. A strobe therefore gets exactly one look. Idle cycles are checked as well, so that a strobe stretched past one cycle is caught. A latched command produces nothing at the cycle of the command itself. Its effect shows only at the cycle that follows the next data write, so the model holds the latched code between the two writes.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] C_RD_MODE   = 8'h20;
  localparam logic [7:0] C_WR_MODE   = 8'h60;
  localparam logic [7:0] C_AUX_OFF   = 8'hA7;
  localparam logic [7:0] C_AUX_ON    = 8'hA8;
  localparam logic [7:0] C_AUX_TEST  = 8'hA9;
  localparam logic [7:0] C_SELF_TEST = 8'hAA;
  localparam logic [7:0] C_KBD_TEST  = 8'hAB;
  localparam logic [7:0] C_KBD_OFF   = 8'hAD;
  localparam logic [7:0] C_KBD_ON    = 8'hAE;
  localparam logic [7:0] C_RD_IN     = 8'hC0;
  localparam logic [7:0] C_RD_PORT   = 8'hD0;
  localparam logic [7:0] C_WR_PORT   = 8'hD1;
  localparam logic [7:0] C_WR_KRSP   = 8'hD2;
  localparam logic [7:0] C_WR_ARSP   = 8'hD3;
  localparam logic [7:0] C_WR_AUX    = 8'hD4;
  localparam logic [7:0] C_GATE_OFF  = 8'hDD;
  localparam logic [7:0] C_GATE_ON   = 8'hDF;
  localparam logic [7:0] C_PULSE_RST = 8'hFE;
  localparam logic [7:0] C_PULSE_NOP = 8'hFF;

  localparam logic [7:0] MODE_RST = 8'h03;
  localparam logic [7:0] STAT_RST = 8'h18;
  localparam logic [7:0] PORT_RST = 8'hCF;

  typedef enum logic [1:0] {SRC_CONST, SRC_MODE, SRC_PORT} rsp_src_e;

  typedef struct packed {
    logic       latch;
    logic       rsp;
    rsp_src_e   src;
    logic [7:0] rsp_const;
    logic [7:0] mode_set;
    logic [7:0] mode_clr;
    logic       irq;
    logic       gate_on;
    logic       gate_off;
    logic       rst_req;
    logic       selftest;
    logic       err;
  } cmd_dec_t;

  typedef struct packed {
    logic kbd_tx;
    logic aux_tx;
    logic rsp;
    logic rsp_aux;
    logic mode_wr;
    logic port_wr;
  } data_route_t;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd,
  output cmd_dec_t          dec
);
  logic [BYTE_W-1:0] folded;

  always_comb begin
    folded = cmd;
    if (cmd[7:4] == 4'hF) folded = cmd[0] ? C_PULSE_NOP : C_PULSE_RST;
  end

  always_comb begin
    dec = '0;
    dec.src = SRC_CONST;
    unique case (folded)
      C_RD_MODE:   begin dec.rsp = 1'b1; dec.src = SRC_MODE; end
      C_RD_PORT:   begin dec.rsp = 1'b1; dec.src = SRC_PORT; end
      C_WR_MODE, C_WR_PORT, C_WR_KRSP, C_WR_ARSP, C_WR_AUX:
                   dec.latch = 1'b1;
      C_AUX_OFF:   dec.mode_set = 8'h20;
      C_AUX_ON:    dec.mode_clr = 8'h20;
      C_KBD_OFF:   begin dec.mode_set = 8'h10; dec.irq = 1'b1; end
      C_KBD_ON:    begin dec.mode_clr = 8'h10; dec.irq = 1'b1; end
      C_AUX_TEST, C_KBD_TEST:
                   dec.rsp = 1'b1;
      C_SELF_TEST: begin dec.rsp = 1'b1; dec.rsp_const = 8'h55; dec.selftest = 1'b1; end
      C_RD_IN:     begin dec.rsp = 1'b1; dec.rsp_const = 8'h80; end
      C_GATE_ON:   dec.gate_on = 1'b1;
      C_GATE_OFF:  dec.gate_off = 1'b1;
      C_PULSE_RST: dec.rst_req = 1'b1;
      C_PULSE_NOP: ;
      default:     dec.err = 1'b1;
    endcase
  end
endmodule

// File: rtl/kbc_data_route.sv
module kbc_data_route
  import kbc_pkg::*;
(
  input  logic [BYTE_W-1:0] pend,
  output data_route_t       route
);
  always_comb begin
    route = '0;
    unique case (pend)
      8'h00:     route.kbd_tx  = 1'b1;
      C_WR_MODE: route.mode_wr = 1'b1;
      C_WR_PORT: route.port_wr = 1'b1;
      C_WR_KRSP: route.rsp     = 1'b1;
      C_WR_ARSP: begin route.rsp = 1'b1; route.rsp_aux = 1'b1; end
      C_WR_AUX:  route.aux_tx  = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/kbc_host_engine.sv
module kbc_host_engine
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] mode_o,
  output logic [BYTE_W-1:0] outport_o,
  output logic              a20_o,
  output logic              xlat_en_o,
  output logic              sys_reset_o,
  output logic              irq_eval_o,
  output logic              cmd_err_o,
  output logic              rsp_valid_o,
  output logic              rsp_aux_o,
  output logic [BYTE_W-1:0] rsp_data_o,
  output logic              kbd_tx_valid_o,
  output logic [BYTE_W-1:0] kbd_tx_data_o,
  output logic              aux_tx_valid_o,
  output logic [BYTE_W-1:0] aux_tx_data_o
);
  localparam int GATE_BIT = 1;
  localparam int RUN_BIT  = 0;
  localparam int XLAT_BIT = 6;
  localparam int CMDL_BIT = 3;
  localparam int SELF_BIT = 2;

  logic [BYTE_W-1:0] pend_q;
  cmd_dec_t          dec;
  data_route_t       route;
  logic [BYTE_W-1:0] rsp_sel;

  kbc_cmd_decode u_dec   (.cmd(host_wdata), .dec(dec));
  kbc_data_route u_route (.pend(pend_q), .route(route));

  always_comb begin
    unique case (dec.src)
      SRC_MODE: rsp_sel = mode_o;
      SRC_PORT: rsp_sel = outport_o;
      default:  rsp_sel = dec.rsp_const;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o       <= STAT_RST;
      mode_o         <= MODE_RST;
      outport_o      <= PORT_RST;
      a20_o          <= PORT_RST[GATE_BIT];
      xlat_en_o      <= MODE_RST[XLAT_BIT];
      pend_q         <= '0;
      sys_reset_o    <= 1'b0;
      irq_eval_o     <= 1'b0;
      cmd_err_o      <= 1'b0;
      rsp_valid_o    <= 1'b0;
      rsp_aux_o      <= 1'b0;
      rsp_data_o     <= '0;
      kbd_tx_valid_o <= 1'b0;
      kbd_tx_data_o  <= '0;
      aux_tx_valid_o <= 1'b0;
      aux_tx_data_o  <= '0;
    end else begin
      sys_reset_o    <= 1'b0;
      irq_eval_o     <= 1'b0;
      cmd_err_o      <= 1'b0;
      rsp_valid_o    <= 1'b0;
      kbd_tx_valid_o <= 1'b0;
      aux_tx_valid_o <= 1'b0;
      if (host_wr && host_addr) begin
        status_o[CMDL_BIT] <= 1'b1;
        if (dec.selftest) status_o[SELF_BIT] <= 1'b1;
        if (dec.latch) pend_q <= host_wdata;
        mode_o <= (mode_o | dec.mode_set) & ~dec.mode_clr;
        irq_eval_o  <= dec.irq;
        cmd_err_o   <= dec.err;
        sys_reset_o <= dec.rst_req;
        if (dec.gate_on) begin
          outport_o[GATE_BIT] <= 1'b1;
          a20_o <= 1'b1;
        end
        if (dec.gate_off) begin
          outport_o[GATE_BIT] <= 1'b0;
          a20_o <= 1'b0;
        end
        if (dec.rsp) begin
          rsp_valid_o <= 1'b1;
          rsp_aux_o   <= 1'b0;
          rsp_data_o  <= rsp_sel;
        end
      end else if (host_wr) begin
        status_o[CMDL_BIT] <= 1'b0;
        pend_q <= '0;
        if (route.kbd_tx) begin
          kbd_tx_valid_o <= 1'b1;
          kbd_tx_data_o  <= host_wdata;
        end
        if (route.aux_tx) begin
          aux_tx_valid_o <= 1'b1;
          aux_tx_data_o  <= host_wdata;
        end
        if (route.rsp) begin
          rsp_valid_o <= 1'b1;
          rsp_aux_o   <= route.rsp_aux;
          rsp_data_o  <= host_wdata;
        end
        if (route.mode_wr) begin
          mode_o     <= host_wdata;
          xlat_en_o  <= host_wdata[XLAT_BIT];
          irq_eval_o <= 1'b1;
        end
        if (route.port_wr) begin
          outport_o   <= host_wdata;
          a20_o       <= host_wdata[GATE_BIT];
          sys_reset_o <= ~host_wdata[RUN_BIT];
        end
      end
    end
  end
endmodule

// File: rtl/kbc_host_engine_chk.sv
module kbc_host_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_wr,
  input logic       host_addr,
  input logic [7:0] host_wdata,
  input logic [7:0] status_o,
  input logic [7:0] mode_o,
  input logic [7:0] outport_o,
  input logic       a20_o,
  input logic       xlat_en_o,
  input logic       sys_reset_o,
  input logic       cmd_err_o,
  input logic       rsp_valid_o,
  input logic       kbd_tx_valid_o,
  input logic       aux_tx_valid_o
);
  p_reset_vals_r1: assert property (@(posedge clk) rst |=> (mode_o == 8'h03 && outport_o == 8'hCF && status_o == 8'h18));

  p_cmd_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr) |=> status_o[3]);

  p_cmd_flag_clr_r10: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_addr) |=> !status_o[3]);

  p_gate_tracks_port_r6: assert property (@(posedge clk) disable iff (rst)
    a20_o == outport_o[1]);

  p_xlat_tracks_mode_r9: assert property (@(posedge clk) disable iff (rst)
    xlat_en_o == mode_o[6]);

  p_reset_single_r7: assert property (@(posedge clk) disable iff (rst)
    (sys_reset_o && !(host_wr)) |=> !sys_reset_o);

  p_err_keeps_state_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_err_o |-> ($stable(mode_o) && $stable(outport_o)));

  p_one_sink_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_valid_o, kbd_tx_valid_o, aux_tx_valid_o, cmd_err_o}));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !host_wr |=> !(rsp_valid_o || kbd_tx_valid_o || aux_tx_valid_o || cmd_err_o || sys_reset_o));

  logic unused_data;
  assign unused_data = ^host_wdata;
endmodule

bind kbc_host_engine kbc_host_engine_chk u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
  .status_o(status_o), .mode_o(mode_o), .outport_o(outport_o), .a20_o(a20_o),
  .xlat_en_o(xlat_en_o), .sys_reset_o(sys_reset_o), .cmd_err_o(cmd_err_o),
  .rsp_valid_o(rsp_valid_o), .kbd_tx_valid_o(kbd_tx_valid_o), .aux_tx_valid_o(aux_tx_valid_o)
);

// File: tb/tb_kbc_host_engine.sv
`timescale 1ns/1ps
module tb_kbc_host_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0;
  logic host_addr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] status_o, mode_o, outport_o, rsp_data_o, kbd_tx_data_o, aux_tx_data_o;
  logic a20_o, xlat_en_o, sys_reset_o, irq_eval_o, cmd_err_o;
  logic rsp_valid_o, rsp_aux_o, kbd_tx_valid_o, aux_tx_valid_o;

  always #2.5 clk = ~clk;

  kbc_host_engine dut (.*);

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0] m_mode, m_port, m_stat, m_pend;
  logic m_a20, m_xlat;
  // expected strobes for the current access
  logic e_rst, e_irq, e_err, e_rsp, e_raux, e_ktx, e_atx;
  logic [7:0] e_rdat, e_kdat, e_adat;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_latch(input logic [7:0] c);
    return c == 8'h60 || c == 8'hD1 || c == 8'hD2 || c == 8'hD3 || c == 8'hD4;
  endfunction

  task automatic model_reset();
    m_mode = 8'h03; m_port = 8'hCF; m_stat = 8'h18; m_pend = 8'h00;
    m_a20 = 1'b1; m_xlat = 1'b0;
  endtask

  task automatic model_access(input logic a, input logic [7:0] d);
    logic [7:0] c;
    {e_rst, e_irq, e_err, e_rsp, e_raux, e_ktx, e_atx} = '0;
    e_rdat = 8'h00; e_kdat = 8'h00; e_adat = 8'h00;
    if (a) begin
      m_stat[3] = 1'b1;
      c = d;
      if (c[7:4] == 4'hF) c = c[0] ? 8'hFF : 8'hFE;
      if (is_latch(c)) m_pend = c;
      else case (c)
        8'h20: begin e_rsp = 1; e_rdat = m_mode; end
        8'hD0: begin e_rsp = 1; e_rdat = m_port; end
        8'hAA: begin e_rsp = 1; e_rdat = 8'h55; m_stat[2] = 1'b1; end
        8'hA9, 8'hAB: e_rsp = 1;
        8'hC0: begin e_rsp = 1; e_rdat = 8'h80; end
        8'hA7: m_mode[5] = 1'b1;
        8'hA8: m_mode[5] = 1'b0;
        8'hAD: begin m_mode[4] = 1'b1; e_irq = 1; end
        8'hAE: begin m_mode[4] = 1'b0; e_irq = 1; end
        8'hDF: begin m_port[1] = 1'b1; m_a20 = 1'b1; end
        8'hDD: begin m_port[1] = 1'b0; m_a20 = 1'b0; end
        8'hFE: e_rst = 1;
        8'hFF: ;
        default: e_err = 1;
      endcase
    end else begin
      m_stat[3] = 1'b0;
      case (m_pend)
        8'h00: begin e_ktx = 1; e_kdat = d; end
        8'h60: begin m_mode = d; m_xlat = d[6]; e_irq = 1; end
        8'hD1: begin m_port = d; m_a20 = d[1]; e_rst = ~d[0]; end
        8'hD2: begin e_rsp = 1; e_rdat = d; end
        8'hD3: begin e_rsp = 1; e_raux = 1; e_rdat = d; end
        8'hD4: begin e_atx = 1; e_adat = d; end
        default: ;
      endcase
      m_pend = 8'h00;
    end
  endtask

  task automatic check_all();
    chk("R5", "mode", mode_o, m_mode);
    chk("R8", "outport", outport_o, m_port);
    chk("R10", "status", status_o, m_stat);
    chk("R6", "a20", a20_o, m_a20);
    chk("R9", "xlat", xlat_en_o, m_xlat);
    chk("R7", "sys_reset", sys_reset_o, e_rst);
    chk("R9", "irq_eval", irq_eval_o, e_irq);
    chk("R11", "cmd_err", cmd_err_o, e_err);
    chk("R4", "rsp_valid", rsp_valid_o, e_rsp);
    if (e_rsp) begin
      chk("R4", "rsp_data", rsp_data_o, e_rdat);
      chk("R12", "rsp_aux", rsp_aux_o, e_raux);
    end
    chk("R3", "kbd_tx_valid", kbd_tx_valid_o, e_ktx);
    if (e_ktx) chk("R3", "kbd_tx_data", kbd_tx_data_o, e_kdat);
    chk("R12", "aux_tx_valid", aux_tx_valid_o, e_atx);
    if (e_atx) chk("R12", "aux_tx_data", aux_tx_data_o, e_adat);
  endtask

  // drive on a falling edge, check at the next falling edge
  task automatic acc(input logic a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    model_access(a, d);
    @(negedge clk);
    host_wr = 1'b0;
    check_all();
  endtask

  task automatic idle();
    {e_rst, e_irq, e_err, e_rsp, e_raux, e_ktx, e_atx} = '0;
    @(negedge clk);
    check_all();
  endtask

  localparam logic [7:0] KNOWN [24] = '{8'h20, 8'h60, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hAD,
    8'hAE, 8'hC0, 8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hDD, 8'hDF, 8'hF0, 8'hF1, 8'hFE,
    8'hFF, 8'hF7, 8'h12, 8'hB5};

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: values right after reset
    idle();
    chk("R1", "reset mode", mode_o, 8'h03);
    chk("R1", "reset status", status_o, 8'h18);
    chk("R1", "reset outport", outport_o, 8'hCF);
    // R3: plain data goes to keyboard transmit
    acc(1'b0, 8'h5A);
    // R4: reply commands
    acc(1'b1, 8'h20); acc(1'b1, 8'hAA); acc(1'b1, 8'hA9); acc(1'b1, 8'hAB);
    acc(1'b1, 8'hC0); acc(1'b1, 8'hD0);
    // R5: mode bit commands
    acc(1'b1, 8'hA7); acc(1'b1, 8'hAD); acc(1'b1, 8'hA8); acc(1'b1, 8'hAE);
    // R6: gate commands
    acc(1'b1, 8'hDD); acc(1'b1, 8'hD0); acc(1'b1, 8'hDF);
    // R7: folding
    acc(1'b1, 8'hFE); idle(); acc(1'b1, 8'hFF); acc(1'b1, 8'hF2); acc(1'b1, 8'hF3);
    // R2/R8: output port write with reset bit low, then latch cleared
    acc(1'b1, 8'hD1); acc(1'b0, 8'hCC); acc(1'b0, 8'h77);
    acc(1'b1, 8'hD1); acc(1'b0, 8'hCF);
    // R9: mode write sets translation
    acc(1'b1, 8'h60); acc(1'b0, 8'h47); acc(1'b1, 8'h20);
    // R12: reply and auxiliary routing
    acc(1'b1, 8'hD2); acc(1'b0, 8'h3C);
    acc(1'b1, 8'hD3); acc(1'b0, 8'hC3);
    acc(1'b1, 8'hD4); acc(1'b0, 8'hE8);
    // R11: unknown command keeps a pending latch and state
    acc(1'b1, 8'hD3); acc(1'b1, 8'h01); acc(1'b0, 8'h99);
    // R2: another command between latch and data keeps the latch
    acc(1'b1, 8'hD4); acc(1'b1, 8'hA7); acc(1'b0, 8'h11);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      logic a;
      a = ($urandom % 3) != 0;
      d = (a && ($urandom % 2 == 0)) ? KNOWN[$urandom % 24] : 8'($urandom);
      acc(a, d);
      if ($urandom % 8 == 0) idle();
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule